// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline Core

This block is a small in-order processor core split into five stages: fetch, decode, execute, memory and writeback. It fetches one 32-bit word per cycle from a read-only instruction port. It executes register and immediate arithmetic and shift operations, and places each result in a 32-entry by 32-bit register file. The memory stage only carries its pipeline register forward, because no data storage is attached. Load and store encodings flow down the pipe but retire without touching any register.

The program counter begins at zero and grows by four on every cycle, since there are no other PC sources. Operand hazards are resolved in the decode stage without any stall cycles. The newest producer wins, in this order: the combinational result of the execute stage, then the execute/memory register, then a write-through path from the writeback stage into the register-file read ports.

For observation, the core exposes its PC and the full contents of the register file.

The pipeline is a plain sequence with no control states. Every cycle it moves from RESET into RUN, and back to RESET only when `rst` is asserted. There are two transitions: reset-entry, which clears the state, and release, which starts fetching at address 0.

Top module: `core_pipe5`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0, every register reads 0, and every pipeline slot holds a bubble that writes nothing.
- R2: After the k-th rising edge following reset release, `pc_out` and `imem_addr` both equal 4·k, and the address is always word-aligned.
- R3: The instruction at address 4·i changes the register file at the (i+5)-th rising edge after release. From then on the register file equals the state a one-at-a-time execution of instructions 0..i would produce.
- R4: Opcode 0110011 with funct3 000 adds the two source registers, or subtracts rs2 from rs1 when bit 30 is set. Opcode 0010011 with funct3 000 adds the sign-extended bits [31:20]. All sums wrap modulo 2^32.
- R5: Under opcode 0010011 (amount in bits [24:20]) or 0110011 (amount in rs2 bits [4:0]), funct3 001 shifts left. Funct3 101 shifts right: logically when bit 30 is clear, and arithmetically when it is set.
- R6: Opcode 0110111 writes bits [31:12] followed by twelve zeros. Opcode 0010111 writes that value plus the instruction's own address.
- R7: Register 0 reads as zero at every port and in every forwarded operand, and writes to it are discarded.
- R8: Opcodes 0000011 (load) and 0100011 (store) change no register. They are never forwarded, and they do not alter the results of the instructions around them.
- R9: A consumer that directly follows its producer, or sits 2 or 3 slots behind it, gets the producer's value with no stall cycle. When several producers in flight target the same register, the youngest one is used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the word being fetched |
| imem_data | input | 32 | Instruction word at `imem_addr`, combinational |
| pc_out | output | 32 | Current fetch PC |
| rf_dump | output | 1024 | Register k occupies bits [32k+31:32k] |

## Verification
The hardest case to reach from the ports is a dependent instruction that reads a register while a load or store naming that same register is in flight ahead of it. The forwarding must skip the non-writing slot and still take an older real producer, or the register file. The bench gets there with an unrolled Fibonacci sequence in which every dependent pair has a load or store aimed at the same register placed between them. It also runs a long random mix over only eight registers, so that producers at distances one, two and three, and writes to register 0, occur often. A behavioural model that retires one instruction five edges after its fetch is compared against the register file and the PC on every cycle.

// File: rtl/core_pkg.sv
package core_pkg;
    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int RAW  = $clog2(NREG);

    localparam logic [6:0] OPC_LUI   = 7'b0110111;
    localparam logic [6:0] OPC_AUIPC = 7'b0010111;
    localparam logic [6:0] OPC_ALUI  = 7'b0010011;
    localparam logic [6:0] OPC_ALUR  = 7'b0110011;
    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_STORE = 7'b0100011;

    typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_SLL, ALU_SRL, ALU_SRA} alu_op_e;
    typedef enum logic [1:0] {ASRC_REG, ASRC_PC, ASRC_ZERO} asrc_e;

    typedef struct packed {
        logic            we;
        logic [RAW-1:0]  rd;
        alu_op_e         op;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
    } issue_t;

    typedef struct packed {
        logic            we;
        logic [RAW-1:0]  rd;
        logic [XLEN-1:0] res;
    } result_t;
endpackage

// File: rtl/core_decode.sv
module core_decode
    import core_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output logic            we,
    output logic [RAW-1:0]  rd,
    output logic [RAW-1:0]  rs1,
    output logic [RAW-1:0]  rs2,
    output alu_op_e         op,
    output asrc_e           asrc,
    output logic            b_imm,
    output logic [XLEN-1:0] imm
);
    logic [6:0]      opc;
    logic [2:0]      f3;
    logic            alt;
    logic [XLEN-1:0] imm_i;
    logic [XLEN-1:0] imm_u;

    assign opc   = instr[6:0];
    assign f3    = instr[14:12];
    assign alt   = instr[30];
    assign rd    = instr[11:7];
    assign rs1   = instr[19:15];
    assign rs2   = instr[24:20];
    assign imm_i = {{(XLEN-12){instr[31]}}, instr[31:20]};
    assign imm_u = {instr[31:12], 12'b0};

    always_comb begin
        we    = 1'b0;
        op    = ALU_ADD;
        asrc  = ASRC_REG;
        b_imm = 1'b0;
        imm   = imm_i;
        unique case (opc)
            OPC_LUI: begin
                we = 1'b1; asrc = ASRC_ZERO; b_imm = 1'b1; imm = imm_u;
            end
            OPC_AUIPC: begin
                we = 1'b1; asrc = ASRC_PC; b_imm = 1'b1; imm = imm_u;
            end
            OPC_ALUI, OPC_ALUR: begin
                b_imm = (opc == OPC_ALUI);
                we    = 1'b1;
                unique case (f3)
                    3'b000:  op = (opc == OPC_ALUR && alt) ? ALU_SUB : ALU_ADD;
                    3'b001:  op = ALU_SLL;
                    3'b101:  op = alt ? ALU_SRA : ALU_SRL;
                    default: we = 1'b0;
                endcase
            end
            default: we = 1'b0;
        endcase
    end
endmodule

// File: rtl/core_alu.sv
module core_alu
    import core_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);
    localparam int SHW = $clog2(XLEN);
    logic [SHW-1:0] sh;
    assign sh = b[SHW-1:0];

    always_comb begin
        unique case (op)
            ALU_SUB: y = a - b;
            ALU_SLL: y = a << sh;
            ALU_SRL: y = a >> sh;
            ALU_SRA: y = XLEN'($signed(a) >>> sh);
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/core_regfile.sv
module core_regfile
    import core_pkg::*;
#(
    parameter int W = XLEN,
    parameter int N = NREG,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra [2],
    output logic [W-1:0]  rdata [2],
    output logic [N*W-1:0] dump
);
    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_rd
        assign rdata[p] = (ra[p] == '0) ? '0 :
                          (we && wa == ra[p]) ? wd : regs[ra[p]];
    end

    for (genvar g = 0; g < N; g++) begin : g_dump
        if (g == 0) begin : g_zero
            assign dump[g*W +: W] = '0;
        end else begin : g_reg
            assign dump[g*W +: W] = regs[g];
        end
    end
endmodule

// File: rtl/core_fwd.sv
module core_fwd
    import core_pkg::*;
(
    input  logic [RAW-1:0]  rs,
    input  logic [XLEN-1:0] rf_val,
    input  logic            x_we,
    input  logic [RAW-1:0]  x_rd,
    input  logic [XLEN-1:0] x_res,
    input  logic            m_we,
    input  logic [RAW-1:0]  m_rd,
    input  logic [XLEN-1:0] m_res,
    output logic [XLEN-1:0] val
);
    logic x_hit, m_hit;
    assign x_hit = x_we && x_rd != '0 && x_rd == rs;
    assign m_hit = m_we && m_rd != '0 && m_rd == rs;
    assign val   = x_hit ? x_res : (m_hit ? m_res : rf_val);
endmodule

// File: rtl/core_pipe5.sv
module core_pipe5
    import core_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    output logic [XLEN-1:0]      imem_addr,
    input  logic [XLEN-1:0]      imem_data,
    output logic [XLEN-1:0]      pc_out,
    output logic [NREG*XLEN-1:0] rf_dump
);
    localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] fd_instr;
    logic [XLEN-1:0] fd_pc;
    logic            fd_valid;
    issue_t          dx_q, dx_d;
    result_t         xm_q, mw_q;

    logic            dec_we, dec_bimm;
    logic [RAW-1:0]  dec_rd;
    logic [RAW-1:0]  rs_idx [2];
    logic [XLEN-1:0] rf_val [2];
    logic [XLEN-1:0] opnd   [2];
    alu_op_e         dec_op;
    asrc_e           dec_asrc;
    logic [XLEN-1:0] dec_imm;
    logic [XLEN-1:0] alu_y;

    assign imem_addr = pc_q;
    assign pc_out    = pc_q;

    core_decode u_dec (
        .instr (fd_instr), .we (dec_we), .rd (dec_rd),
        .rs1 (rs_idx[0]), .rs2 (rs_idx[1]), .op (dec_op),
        .asrc (dec_asrc), .b_imm (dec_bimm), .imm (dec_imm)
    );

    core_regfile u_rf (
        .clk (clk), .rst (rst), .we (mw_q.we), .wa (mw_q.rd), .wd (mw_q.res),
        .ra (rs_idx), .rdata (rf_val), .dump (rf_dump)
    );

    for (genvar p = 0; p < 2; p++) begin : g_fwd
        core_fwd u_fwd (
            .rs (rs_idx[p]), .rf_val (rf_val[p]),
            .x_we (dx_q.we), .x_rd (dx_q.rd), .x_res (alu_y),
            .m_we (xm_q.we), .m_rd (xm_q.rd), .m_res (xm_q.res),
            .val (opnd[p])
        );
    end

    always_comb begin
        dx_d.we = dec_we && fd_valid;
        dx_d.rd = dec_rd;
        dx_d.op = dec_op;
        unique case (dec_asrc)
            ASRC_PC:   dx_d.a = fd_pc;
            ASRC_ZERO: dx_d.a = '0;
            default:   dx_d.a = opnd[0];
        endcase
        dx_d.b = dec_bimm ? dec_imm : opnd[1];
    end

    core_alu u_alu (.op (dx_q.op), .a (dx_q.a), .b (dx_q.b), .y (alu_y));

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            fd_instr <= '0;
            fd_pc    <= '0;
            fd_valid <= 1'b0;
            dx_q     <= '0;
            xm_q     <= '0;
            mw_q     <= '0;
        end else begin
            pc_q     <= pc_q + PC_STEP;
            fd_instr <= imem_data;
            fd_pc    <= pc_q;
            fd_valid <= 1'b1;
            dx_q     <= dx_d;
            xm_q     <= '{we: dx_q.we, rd: dx_q.rd, res: alu_y};
            mw_q     <= xm_q;
        end
    end
endmodule

// File: rtl/core_pipe5_chk.sv
module core_pipe5_chk
    import core_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [XLEN-1:0]      pc_q,
    input logic [XLEN-1:0]      imem_addr,
    input logic [NREG*XLEN-1:0] rf_dump,
    input logic                 fd_valid,
    input logic [6:0]           fd_opc,
    input logic                 dx_we,
    input logic                 mw_we
);
    logic run_seen;
    always_ff @(posedge clk) begin
        if (rst) run_seen <= 1'b0;
        else     run_seen <= 1'b1;
    end

    AST_RESET_PC_ZERO: assert property (@(posedge clk) rst |=> pc_q == '0); // R1
    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        run_seen |-> pc_q == $past(pc_q) + XLEN'(4)); // R2
    AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (rst)
        imem_addr[1:0] == 2'b00); // R2
    AST_X0_ZERO: assert property (@(posedge clk) disable iff (rst)
        rf_dump[XLEN-1:0] == '0); // R7
    AST_MEMOP_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
        (fd_valid && (fd_opc == OPC_LOAD || fd_opc == OPC_STORE)) |=> !dx_we); // R8
    AST_RF_HOLD: assert property (@(posedge clk) disable iff (rst)
        !mw_we |=> $stable(rf_dump)); // R8
endmodule

bind core_pipe5 core_pipe5_chk u_chk (
    .clk (clk), .rst (rst), .pc_q (pc_q), .imem_addr (imem_addr),
    .rf_dump (rf_dump), .fd_valid (fd_valid), .fd_opc (fd_instr[6:0]),
    .dx_we (dx_q.we), .mw_we (mw_q.we)
);

// File: tb/core_pipe5_tb.sv
module core_pipe5_tb;
    localparam logic [31:0] NOP = 32'h0000_0013;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [31:0]   imem_addr, imem_data, pc_out;
    logic [1023:0] rf_dump;

    logic [31:0] prog [256];
    int          plen = 0;
    logic [31:0] mreg [32];
    int          checks = 0, failures = 0;

    always #4 clk = ~clk;

    always_comb imem_data = (int'(imem_addr[31:2]) < plen) ? prog[imem_addr[9:2]] : NOP;

    core_pipe5 u_dut (.clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
                      .pc_out(pc_out), .rf_dump(rf_dump));

    function automatic logic [31:0] e_r(logic [6:0] f7, logic [4:0] s2, logic [4:0] s1, logic [2:0] f3, logic [4:0] d);
        return {f7, s2, s1, f3, d, 7'h33};
    endfunction
    function automatic logic [31:0] e_i(logic [11:0] im, logic [4:0] s1, logic [2:0] f3, logic [4:0] d, logic [6:0] opc);
        return {im, s1, f3, d, opc};
    endfunction
    function automatic logic [31:0] e_u(logic [19:0] im, logic [4:0] d, logic [6:0] opc);
        return {im, d, opc};
    endfunction
    function automatic logic [31:0] e_s(logic [11:0] im, logic [4:0] s2, logic [4:0] s1, logic [2:0] f3);
        return {im[11:5], s2, s1, f3, im[4:0], 7'h23};
    endfunction

    task automatic put(input logic [31:0] w);
        prog[plen] = w;
        plen++;
    endtask

    function automatic void mstep(logic [31:0] ins, logic [31:0] ipc);
        logic [31:0] va, vb, ii, r;
        logic [4:0]  sa;
        bit          w;
        va = mreg[ins[19:15]];
        vb = mreg[ins[24:20]];
        ii = {{20{ins[31]}}, ins[31:20]};
        r  = '0;
        w  = 1'b1;
        case (ins[6:0])
            7'h37: r = {ins[31:12], 12'h000};
            7'h17: r = ipc + {ins[31:12], 12'h000};
            7'h13, 7'h33: begin
                sa = (ins[6:0] == 7'h13) ? ins[24:20] : vb[4:0];
                case (ins[14:12])
                    3'd0: r = (ins[6:0] == 7'h13) ? va + ii : (ins[30] ? va - vb : va + vb);
                    3'd1: r = va << sa;
                    3'd5: r = ins[30] ? 32'($signed(va) >>> sa) : va >> sa;
                    default: w = 1'b0;
                endcase
            end
            default: w = 1'b0;
        endcase
        if (w && ins[11:7] != 5'd0) mreg[ins[11:7]] = r;
    endfunction

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run_prog(input string tag);
        logic [31:0] ins;
        int          bad;
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 32; i++) mreg[i] = '0;
        check_val("R1 reset pc", pc_out, 32'h0);
        checks++;
        if (rf_dump !== '0) begin
            failures++;
            $display("FAIL R1 reset regfile act=%h exp=0", rf_dump[63:0]);
        end
        rst = 1'b0;
        for (int n = 1; n <= plen + 8; n++) begin
            @(posedge clk);
            if (n >= 5) begin
                ins = (n - 5 < plen) ? prog[n-5] : NOP;
                mstep(ins, 32'((n - 5) * 4));
            end
            @(negedge clk);
            check_val("R2 pc step", pc_out, 32'(n * 4));
            check_val("R2 fetch addr", imem_addr, 32'(n * 4));
            checks++;
            bad = -1;
            for (int k = 0; k < 32; k++)
                if (rf_dump[k*32 +: 32] !== mreg[k] && bad < 0) bad = k;
            if (bad >= 0) begin
                failures++;
                $display("FAIL R3 %s cycle %0d x%0d act=%h exp=%h", tag, n, bad,
                         rf_dump[bad*32 +: 32], mreg[bad]);
            end
        end
    endtask

    function automatic logic [31:0] rx(int k);
        return rf_dump[k*32 +: 32];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // arithmetic chains, forwarding distances 1..3, youngest producer priority
        plen = 0;
        put(e_i(12'd5, 0, 0, 1, 7'h13));
        put(e_i(12'd3, 1, 0, 2, 7'h13));
        put(e_r(7'h00, 1, 2, 0, 3));
        put(e_r(7'h20, 2, 3, 0, 4));
        put(e_r(7'h00, 4, 4, 0, 5));
        put(e_i(-12'sd7, 1, 0, 1, 7'h13));
        put(e_r(7'h00, 5, 1, 0, 6));
        put(e_r(7'h20, 6, 0, 0, 7));
        put(e_i(12'd2047, 0, 0, 8, 7'h13));
        put(e_i(12'd2047, 8, 0, 8, 7'h13));
        put(e_i(12'd1, 0, 0, 9, 7'h13));
        put(e_i(12'd2, 0, 0, 9, 7'h13));
        put(e_i(12'd3, 0, 0, 9, 7'h13));
        put(e_r(7'h00, 9, 9, 0, 10));
        put(e_i(12'd100, 0, 0, 11, 7'h13));
        put(NOP);
        put(NOP);
        put(e_r(7'h00, 11, 11, 0, 12));
        put(e_u(20'h80000, 13, 7'h37));
        put(e_r(7'h00, 13, 13, 0, 14));
        run_prog("R4 R9 chains");
        check_val("R9 dist1+2 x3", rx(3), 32'd13);
        check_val("R4 sub negative x7", rx(7), 32'hFFFF_FFF8);
        check_val("R4 addi x8", rx(8), 32'd4094);
        check_val("R9 youngest wins x10", rx(10), 32'd6);
        check_val("R9 dist3 x12", rx(12), 32'd200);
        check_val("R4 wrap x14", rx(14), 32'd0);

        // shifts at boundary amounts
        plen = 0;
        put(e_u(20'h80000, 1, 7'h37));
        put(e_i(12'd1, 1, 0, 1, 7'h13));
        put(e_i({7'h20, 5'd31}, 1, 5, 2, 7'h13));
        put(e_i({7'h00, 5'd31}, 1, 5, 3, 7'h13));
        put(e_i({7'h00, 5'd0}, 1, 1, 4, 7'h13));
        put(e_i({7'h00, 5'd31}, 1, 1, 5, 7'h13));
        put(e_i(12'd33, 0, 0, 6, 7'h13));
        put(e_r(7'h00, 6, 1, 1, 7));
        put(e_r(7'h20, 6, 1, 5, 8));
        put(e_r(7'h00, 6, 1, 5, 9));
        put(e_i(12'hFFF, 0, 0, 10, 7'h13));
        put(e_r(7'h00, 10, 1, 5, 11));
        put(e_r(7'h20, 10, 1, 5, 12));
        run_prog("R5 shifts");
        check_val("R5 srai 31 x2", rx(2), 32'hFFFF_FFFF);
        check_val("R5 slli 0 x4", rx(4), 32'h8000_0001);
        check_val("R5 slli 31 x5", rx(5), 32'h8000_0000);
        check_val("R5 sll amount low bits x7", rx(7), 32'h0000_0002);
        check_val("R5 sra x8", rx(8), 32'hC000_0000);
        check_val("R5 srl x9", rx(9), 32'h4000_0000);
        check_val("R5 sra 31 x12", rx(12), 32'hFFFF_FFFF);

        // upper immediates and register zero
        plen = 0;
        put(e_u(20'h12345, 1, 7'h37));
        put(e_u(20'h00001, 2, 7'h17));
        put(e_u(20'h00000, 3, 7'h17));
        put(e_i(12'd55, 0, 0, 0, 7'h13));
        put(e_r(7'h00, 0, 0, 0, 4));
        put(e_i(12'd9, 0, 0, 5, 7'h13));
        put(e_r(7'h00, 5, 5, 0, 0));
        put(e_r(7'h00, 5, 0, 0, 6));
        put(e_u(20'hFFFFF, 0, 7'h37));
        put(e_i(12'd0, 0, 0, 7, 7'h13));
        put(e_u(20'hFFFFF, 8, 7'h37));
        put(e_i(12'hFFF, 8, 0, 8, 7'h13));
        run_prog("R6 R7 upper and zero");
        check_val("R6 lui x1", rx(1), 32'h1234_5000);
        check_val("R6 auipc x2", rx(2), 32'h0000_1004);
        check_val("R6 auipc x3", rx(3), 32'h0000_0008);
        check_val("R7 x0 not forwarded x6", rx(6), 32'd9);
        check_val("R7 x0 after lui x7", rx(7), 32'd0);
        check_val("R6 lui+addi x8", rx(8), 32'hFFFF_EFFF);
        check_val("R7 x0 zero", rx(0), 32'd0);

        // Fibonacci(4) with load/store encodings aimed at live registers
        plen = 0;
        put(e_i(12'd0, 0, 0, 5, 7'h13));
        put(e_i(12'd1, 0, 0, 6, 7'h13));
        for (int it = 2; it <= 4; it++) begin
            put(e_r(7'h00, 6, 5, 0, 7));
            put(e_i(12'd0, 7, 3'b010, 6, 7'h03));
            put(e_r(7'h00, 0, 6, 0, 5));
            put(e_i(12'd0, 5, 3'b000, 7, 7'h03));
            put(e_r(7'h00, 0, 7, 0, 6));
            put(e_s(12'd8, 6, 5, 3'b010));
            put(e_s(12'd1, 7, 6, 3'b000));
        end
        put(e_r(7'h00, 0, 7, 0, 10));
        run_prog("R8 memops silent");
        check_val("R8 fib result x10", rx(10), 32'd3);
        check_val("R8 f1 x5", rx(5), 32'd2);
        check_val("R8 f2 x6", rx(6), 32'd3);
        check_val("R8 fi x7", rx(7), 32'd3);

        // random mix over a small register set
        plen = 0;
        for (int i = 0; i < 200; i++) begin
            logic [4:0]  d, a, b;
            logic [11:0] im;
            d  = 5'($urandom_range(0, 7));
            a  = 5'($urandom_range(0, 7));
            b  = 5'($urandom_range(0, 7));
            im = 12'($urandom);
            case ($urandom_range(0, 11))
                0:  put(e_r(7'h00, b, a, 0, d));
                1:  put(e_r(7'h20, b, a, 0, d));
                2:  put(e_i(im, a, 0, d, 7'h13));
                3:  put(e_r(7'h00, b, a, 1, d));
                4:  put(e_r(7'h00, b, a, 5, d));
                5:  put(e_r(7'h20, b, a, 5, d));
                6:  put(e_i({7'h00, im[4:0]}, a, 1, d, 7'h13));
                7:  put(e_i({im[0] ? 7'h20 : 7'h00, im[4:0]}, a, 5, d, 7'h13));
                8:  put(e_u({im, im[7:0]}, d, 7'h37));
                9:  put(e_u({im, im[11:4]}, d, 7'h17));
                10: put(e_i(im, a, im[0] ? 3'b010 : 3'b000, d, 7'h03));
                default: put(e_s(im, b, a, im[1] ? 3'b010 : 3'b000));
            endcase
        end
        run_prog("R9 random mix");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule